// File: doc/BRIEF.md
# Frequency-Change Watchdog With Revert

This block supervises a running change of the clock-generator output frequency. Software programs a 4-bit timeout in whole seconds and then requests a new frequency, either by writing the software frequency code or by writing the direct divider registers. The request starts a seconds timer. If software is still alive, it writes a zero timeout before expiry and the new frequency stays. If the system hangs, the timer expires. The block then sets an alarm flag and drives a low system-reset pulse. It also switches the active frequency code to a safe revert setting.

A control bit picks the revert setting. It is either the latched hardware strap code or the software code that was written before the one that caused the hang. A prescaler turns the core clock into one-second ticks, and its ratio is a parameter. The reset pulse reaches the pin only when the shared pin is configured as a reset output.

Top module: `freq_guard_wdt`

## Requirements
- R1: After reset, alarm is 0, sys_rst_n is 1, no timer runs, and the stored timeout and both software code history entries are 0.
- R2: When no revert is in force, freq_code equals the latest software code if sw_sel_en is 1, and equals hw_code if sw_sel_en is 0.
- R3: A pulse on sw_code_wr or dial_wr starts the timer only while the stored timeout code is nonzero. Writing a nonzero timeout code while the timer is idle does not start it.
- R4: Expiry happens on the clock edge exactly timeout × TICK_DIV cycles after the edge that started the timer. alarm becomes 1 in the cycle that follows.
- R5: Writing timeout code 0 before expiry stops the timer. No alarm and no reset pulse follow, and freq_code keeps the newly selected code.
- R6: Writing timeout code 0 clears alarm on the next edge.
- R7: On expiry, sys_rst_n goes low for exactly PULSE_CYCLES cycles, but only while pin_mode is 0. While pin_mode is 1, sys_rst_n stays 1.
- R8: On expiry with revert_sel = 0, freq_code becomes the hw_code value sampled at the expiry edge.
- R9: On expiry with revert_sel = 1, freq_code becomes the software code written before the most recent software code write.
- R10: Writing a nonzero timeout code while the timer runs restarts the count from zero, using the new code as the limit.
- R11: A new frequency request (sw_code_wr or dial_wr) while the timer runs restarts the count from zero.
- R12: A software code write ends any revert in force, and freq_code follows R2 again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_code | input | 5 | Latched hardware strap frequency code |
| sw_sel_en | input | 1 | 1 = software code drives the frequency |
| sw_code_wr | input | 1 | Strobe: software frequency code written |
| sw_code_in | input | 5 | New software frequency code |
| dial_wr | input | 1 | Strobe: direct divider registers written |
| tmo_wr | input | 1 | Strobe: timeout code written |
| tmo_code | input | 4 | Timeout in seconds, 0 = off |
| revert_sel | input | 1 | 0 = revert to strap code, 1 = previous software code |
| pin_mode | input | 1 | 0 = shared pin is reset output, 1 = stop input |
| freq_code | output | 5 | Active frequency code |
| alarm | output | 1 | Watchdog expired flag |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The bench goes after expiry timing to the exact cycle. A prescaler or seconds compare that is off by one would move alarm by one tick or one cycle. It covers a timeout that is cleared just before expiry, which a design that ignores the clear would turn into a spurious reset. It also restarts the timer both by rewriting the timeout and by a second request; a design that failed to restart would expire early. Finally, it checks both revert sources and the pin-mode gate. Mixing up the history entries would revert to the hanging code itself, and a missing gate would pulse a pin that is configured as an input.

// File: rtl/fgw_pkg.sv
// Shared widths and types for the frequency-change watchdog.
// Assumes a 5-bit frequency code and a 4-bit seconds timeout field.
package fgw_pkg;
    localparam int FS_W  = 5;
    localparam int TMO_W = 4;
    localparam int HIST  = 2;
    typedef logic [FS_W-1:0]  fcode_t;
    typedef logic [TMO_W-1:0] tmo_t;
endpackage

// File: rtl/fgw_tick_div.sv
// Seconds prescaler: counts core cycles while run is high and flags the
// last cycle of each tick period. Assumes DIV >= 2; clr restarts the period.
module fgw_tick_div #(
    parameter int DIV = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic last
);
    localparam int W = $clog2(DIV + 1);
    logic [W-1:0] cnt_q;

    assign last = run && (cnt_q == W'(DIV - 1));

    // Advance the cycle count inside the current tick period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (last)      cnt_q <= '0;
        else if (run)       cnt_q <= cnt_q + W'(1);
    end

    p_tick_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < W'(DIV));
endmodule

// File: rtl/fgw_pulse.sv
// Reset pulse stretcher: start loads LEN cycles, busy stays high until they
// have elapsed. Assumes LEN >= 1.
module fgw_pulse #(
    parameter int LEN = 1_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int W = $clog2(LEN + 1);
    logic [W-1:0] left_q;

    assign busy = (left_q != '0);

    // Load or count down the remaining pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n)      left_q <= '0;
        else if (start)  left_q <= W'(LEN);
        else if (busy)   left_q <= left_q - W'(1);
    end

    p_pulse_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/fgw_code_sel.sv
// Frequency code selection: keeps a short history of software codes and a
// revert code captured on expiry. Assumes expire never coincides with sw_wr.
module fgw_code_sel
    import fgw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sw_wr,
    input  fcode_t sw_in,
    input  fcode_t hw_code,
    input  logic   sw_sel_en,
    input  logic   expire,
    input  logic   revert_sel,
    output fcode_t freq_code
);
    fcode_t hist_q [HIST];
    logic   rev_q;
    fcode_t rcode_q;

    // Shift the software code history on each accepted code write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < HIST; i++) begin
            if (!rst_n)      hist_q[i] <= '0;
            else if (sw_wr)  hist_q[i] <= (i == 0) ? sw_in : hist_q[i-1];
        end
    end

    // Capture the revert code on expiry; a new software write ends the revert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rev_q   <= 1'b0;
            rcode_q <= '0;
        end else if (expire) begin
            rev_q   <= 1'b1;
            rcode_q <= revert_sel ? hist_q[HIST-1] : hw_code;
        end else if (sw_wr) begin
            rev_q   <= 1'b0;
        end
    end

    assign freq_code = rev_q ? rcode_q : (sw_sel_en ? hist_q[0] : hw_code);

    p_revert_prev_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && revert_sel) |=> freq_code == $past(hist_q[HIST-1]));
    p_new_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !expire) |=> (!sw_sel_en || freq_code == $past(sw_in)));
endmodule

// File: rtl/freq_guard_wdt.sv
// Frequency-change watchdog top: arms on a frequency request while a nonzero
// timeout is stored, counts whole seconds, and on expiry raises alarm, pulses
// the reset output and reverts the frequency code. Assumes software does not
// write the timeout in the same cycle as a frequency request.
module freq_guard_wdt
    import fgw_pkg::*;
#(
    parameter int TICK_DIV     = 25_000_000,
    parameter int PULSE_CYCLES = 1_500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] hw_code,
    input  logic       sw_sel_en,
    input  logic       sw_code_wr,
    input  logic [4:0] sw_code_in,
    input  logic       dial_wr,
    input  logic       tmo_wr,
    input  logic [3:0] tmo_code,
    input  logic       revert_sel,
    input  logic       pin_mode,
    output logic [4:0] freq_code,
    output logic       alarm,
    output logic       sys_rst_n
);
    tmo_t tmo_q;
    tmo_t sec_q;
    logic running_q;
    logic tick_last;
    logic pulse_busy;
    logic stop_req;
    logic start;
    logic expire;

    assign stop_req = tmo_wr && (tmo_code == '0);
    assign start    = ((sw_code_wr || dial_wr) && (tmo_q != '0))
                   || (tmo_wr && (tmo_code != '0) && running_q);
    assign expire   = running_q && tick_last && (sec_q == tmo_q - TMO_W'(1))
                   && !sw_code_wr && !dial_wr && !tmo_wr;

    // Store the programmed timeout code.
    always_ff @(posedge clk) begin
        if (!rst_n)       tmo_q <= '0;
        else if (tmo_wr)  tmo_q <= tmo_code;
    end

    // Run state: clear stops, a request or rewrite restarts, expiry ends.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_req)  running_q <= 1'b0;
        else if (start)          running_q <= 1'b1;
        else if (expire)         running_q <= 1'b0;
    end

    // Whole-second counter advanced by the prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n || start || stop_req)  sec_q <= '0;
        else if (tick_last)               sec_q <= sec_q + TMO_W'(1);
    end

    // Alarm flag: set on expiry, cleared by a zero timeout write.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_req)  alarm <= 1'b0;
        else if (expire)         alarm <= 1'b1;
    end

    fgw_tick_div #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start || stop_req || expire),
        .run   (running_q),
        .last  (tick_last)
    );

    fgw_pulse #(.LEN(PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (expire),
        .busy  (pulse_busy)
    );

    fgw_code_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_wr      (sw_code_wr),
        .sw_in      (sw_code_in),
        .hw_code    (hw_code),
        .sw_sel_en  (sw_sel_en),
        .expire     (expire),
        .revert_sel (revert_sel),
        .freq_code  (freq_code)
    );

    assign sys_rst_n = !(pulse_busy && !pin_mode);

    p_alarm_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !alarm);
    p_stop_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !running_q);
    p_stop_mode_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mode |-> sys_rst_n);
    p_pulse_on_expiry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (sys_rst_n == pin_mode));
    p_revert_hw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !revert_sel) |=> freq_code == $past(hw_code));
    p_zero_tmo_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_q == '0) |-> !expire);
endmodule

// File: tb/freq_guard_wdt_tb.sv
module freq_guard_wdt_tb;
    localparam int DIV = 8;
    localparam int PLS = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] hw_code = 5'h0A;
    logic       sw_sel_en = 1'b0;
    logic       sw_code_wr = 1'b0;
    logic [4:0] sw_code_in = '0;
    logic       dial_wr = 1'b0;
    logic       tmo_wr = 1'b0;
    logic [3:0] tmo_code = '0;
    logic       revert_sel = 1'b0;
    logic       pin_mode = 1'b0;
    logic [4:0] freq_code;
    logic       alarm;
    logic       sys_rst_n;

    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R1";
    bit    done = 1'b0;

    always #2 clk = ~clk;

    freq_guard_wdt #(.TICK_DIV(DIV), .PULSE_CYCLES(PLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .hw_code(hw_code), .sw_sel_en(sw_sel_en),
        .sw_code_wr(sw_code_wr), .sw_code_in(sw_code_in), .dial_wr(dial_wr),
        .tmo_wr(tmo_wr), .tmo_code(tmo_code), .revert_sel(revert_sel),
        .pin_mode(pin_mode), .freq_code(freq_code), .alarm(alarm),
        .sys_rst_n(sys_rst_n)
    );

    // Behavioural reference: elapsed cycles against a deadline.
    int m_cur, m_prev, m_tmo, m_el, m_left, m_rcode;
    bit m_run, m_alarm, m_rev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur = 0; m_prev = 0; m_tmo = 0; m_el = 0; m_left = 0;
            m_rcode = 0; m_run = 0; m_alarm = 0; m_rev = 0;
        end else begin
            bit fire, restart;
            fire = m_run && !sw_code_wr && !dial_wr && !tmo_wr
                   && (m_el + 1 == m_tmo * DIV);
            restart = ((sw_code_wr || dial_wr) && m_tmo != 0)
                      || (tmo_wr && tmo_code != 0 && m_run);
            if (m_left > 0) m_left--;
            if (tmo_wr && tmo_code == 0) begin
                m_run = 0; m_alarm = 0;
            end else if (restart) begin
                m_run = 1; m_el = 0;
            end else if (fire) begin
                m_run = 0;
            end else if (m_run) begin
                m_el++;
            end
            if (fire && !(tmo_wr && tmo_code == 0)) m_alarm = 1;
            if (fire) begin
                m_left = PLS; m_rev = 1;
                m_rcode = revert_sel ? m_prev : int'(hw_code);
            end else if (sw_code_wr) begin
                m_rev = 0;
            end
            if (sw_code_wr) begin m_prev = m_cur; m_cur = int'(sw_code_in); end
            if (tmo_wr) m_tmo = int'(tmo_code);
        end
    end

    // Compare every cycle, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            int ef; bit ea, er;
            ef = m_rev ? m_rcode : (sw_sel_en ? m_cur : int'(hw_code));
            ea = m_alarm;
            er = !(m_left > 0 && !pin_mode);
            n_checks++;
            if (int'(freq_code) !== ef || alarm !== ea || sys_rst_n !== er) begin
                n_errors++;
                $display("FAIL %s: freq=%0h alarm=%0b rst_n=%0b expected freq=%0h alarm=%0b rst_n=%0b",
                         tag, freq_code, alarm, sys_rst_n, ef, ea, er);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic wr_sw(input logic [4:0] c);
        @(negedge clk); sw_code_wr = 1'b1; sw_code_in = c;
        @(negedge clk); sw_code_wr = 1'b0;
    endtask

    task automatic wr_tmo(input logic [3:0] c);
        @(negedge clk); tmo_wr = 1'b1; tmo_code = c;
        @(negedge clk); tmo_wr = 1'b0;
    endtask

    task automatic wr_dial();
        @(negedge clk); dial_wr = 1'b1;
        @(negedge clk); dial_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #400000;
        n_errors++; n_checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state
        idle(3); rst_n = 1'b1; idle(1);
        chk("R1", int'(alarm), 0); chk("R1", int'(sys_rst_n), 1);
        chk("R1", int'(freq_code), 'h0A);
        // R2: strap then software code
        tag = "R2"; wr_sw(5'h03); idle(2);
        chk("R2", int'(freq_code), 'h0A);
        sw_sel_en = 1'b1; idle(1); chk("R2", int'(freq_code), 'h03);
        // R3: nonzero timeout while idle does not start
        tag = "R3"; wr_tmo(4'd2); idle(40); chk("R3", int'(alarm), 0);
        // R4, R7, R8: arm with 2 s, expire at 16 cycles
        tag = "R4"; wr_sw(5'h07);
        repeat (15) @(posedge clk); #1 chk("R4", int'(alarm), 0);
        @(posedge clk); #1 chk("R4", int'(alarm), 1);
        chk("R7", int'(sys_rst_n), 0); chk("R8", int'(freq_code), 'h0A);
        tag = "R7"; repeat (PLS - 1) @(posedge clk); #1 chk("R7", int'(sys_rst_n), 0);
        @(posedge clk); #1 chk("R7", int'(sys_rst_n), 1);
        // R6, R12
        tag = "R6"; wr_tmo(4'd0); chk("R6", int'(alarm), 0);
        tag = "R12"; wr_sw(5'h11); idle(1); chk("R12", int'(freq_code), 'h11);
        // R9 with pin_mode = 1
        tag = "R9"; revert_sel = 1'b1; pin_mode = 1'b1;
        wr_tmo(4'd1); wr_sw(5'h15); idle(12);
        chk("R9", int'(freq_code), 'h11); chk("R7", int'(sys_rst_n), 1);
        chk("R9", int'(alarm), 1);
        // R5: dial request then clear before expiry
        tag = "R5"; pin_mode = 1'b0; wr_tmo(4'd0); wr_tmo(4'd3); wr_sw(5'h19);
        wr_tmo(4'd0); wr_tmo(4'd3); wr_dial(); idle(10); wr_tmo(4'd0); idle(40);
        chk("R5", int'(alarm), 0); chk("R5", int'(sys_rst_n), 1);
        chk("R5", int'(freq_code), 'h19);
        // R10: rewrite timeout mid-count restarts from zero
        tag = "R10"; wr_tmo(4'd2); wr_sw(5'h1C); idle(10); wr_tmo(4'd1);
        idle(5); chk("R10", int'(alarm), 0); idle(5); chk("R10", int'(alarm), 1);
        // R11: second request mid-count restarts
        tag = "R11"; wr_tmo(4'd0); wr_tmo(4'd1); wr_sw(5'h02); idle(5);
        wr_dial(); idle(5); chk("R11", int'(alarm), 0); idle(5);
        chk("R11", int'(alarm), 1);
        idle(20);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule